// File: doc/BRIEF.md
# Sixteen-Channel DMA Control and Interrupt Register Block

This block is the software-facing control plane of a multi-channel DMA engine. A processor programs each channel through a small register window: the buffer base address, the number of words per row, the number of rows, a row pitch, and a control word that selects burst length and transfer direction. The write to a channel's base-address register is the trigger. That write launches the channel, so software writes every other parameter first. The block then emits a one-cycle launch pulse and presents the channel's stored parameters to the address sequencer, which lies outside this block.

Completion and half-buffer events come back from the sequencers. Each event sets that channel's bit in an interrupt status bitmap, which software clears by writing ones. An enable bitmap masks the status bits into a single interrupt line. A stop strobe register issues one-cycle stop pulses to any set of channels. A loop-control register enables circular operation for a channel only when both of its paired bits are set.

The register port is a simple single-cycle write / registered read interface. The bus address is a byte address, and the two low bits are ignored.

Top module: `chan_dma_csr`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and no launch or stop pulse is driven.
- R2: Channel n owns four registers at byte offset 0x10*n: base address at +0x0 (32 bits), row length at +0x4 and row count at +0x8 (low 16 bits kept, upper bits read 0), and control at +0xC (low 6 bits kept). Each reads back its last written value.
- R3: A write to channel n's base-address register drives `go_pulse[n]` high for exactly the one cycle after the write edge. At that time `ch_base`, `ch_rowlen` and `ch_rows` for channel n show the written values. Writes to a channel's other registers produce no launch pulse.
- R4: Pitch registers form an array at byte 0x100 + 4*n (low 16 bits kept). Each reads back and drives `ch_pitch` for channel n.
- R5: Writing data d to byte 0x140 drives `halt_pulse` = d[15:0] for the one cycle after the write edge. This register reads as 0.
- R6: A high `evt_done[n]` or `evt_half[n]` at a clock edge sets bit n of the status register at byte 0x144.
- R7: Writing a 1 to bit n of the status register clears that bit. Written zeros leave bits unchanged.
- R8: If an event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R9: `irq` is high exactly when some status bit n and bit n of the enable register at byte 0x148 are both 1. The enable register reads back.
- R10: The loop-control register at byte 0x150 reads back all 32 bits. `ch_loop[n]` is high only when both bit n and bit n+16 are 1.
- R11: Control bit 4 drives `ch_burst4[n]` (burst of four) and control bit 5 drives `ch_to_dev[n]` (1 = memory to device, 0 = device to memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_done | input | 16 | Per-channel transfer-done events |
| evt_half | input | 16 | Per-channel half-buffer events |
| go_pulse | output | 16 | Per-channel launch pulses |
| halt_pulse | output | 16 | Per-channel stop pulses |
| ch_base | output | 512 | Base address per channel, 32 bits each |
| ch_rowlen | output | 256 | Row length per channel, 16 bits each |
| ch_rows | output | 256 | Row count per channel, 16 bits each |
| ch_pitch | output | 256 | Row pitch per channel, 16 bits each |
| ch_burst4 | output | 16 | Burst-of-four select per channel |
| ch_to_dev | output | 16 | Direction per channel |
| ch_loop | output | 16 | Loop operation enable per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The launch path is driven with parameter writes that must not fire, followed by the arming write. This shows whether the pulse is tied to the address register alone, and whether the parameters are in place when the pulse appears. Status is exercised with done and half events on different channels, clears with mixed one and zero bits, and an event colliding with its own clear. These separate set priority from clear masking. Enable patterns on and off a set bit show whether the interrupt is masked per bit. Loop patterns with only one of a channel's paired bits set, and then both, show that the pairing is an AND.

// File: rtl/chan_dma_pkg.sv
package chan_dma_pkg;
  // Byte-address width of the register window.
  localparam int BA_W = 9;
  localparam int WA_W = BA_W - 2;
  // Word addresses of the shared registers.
  localparam logic [WA_W-1:0] W_PITCH0 = 7'h40;
  localparam logic [WA_W-1:0] W_STOP   = 7'h50;
  localparam logic [WA_W-1:0] W_STAT   = 7'h51;
  localparam logic [WA_W-1:0] W_IEN    = 7'h52;
  localparam logic [WA_W-1:0] W_LOOP   = 7'h54;
  // Offset of the second loop-enable bit for a channel.
  localparam int LOOP_PAIR = 16;
  // Control field positions.
  localparam int CTL_W     = 6;
  localparam int CTL_BURST = 4;
  localparam int CTL_DIR   = 5;
  // Per-channel register selectors.
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_RLEN = 2'd1,
    SEL_ROWS = 2'd2,
    SEL_CTL  = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/chan_dma_rst_sync.sv
module chan_dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/chan_dma_chregs.sv
module chan_dma_chregs
  import chan_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       wdata,
  input  logic              we_base,
  input  logic              we_rlen,
  input  logic              we_rows,
  input  logic              we_ctl,
  input  logic              we_pitch,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  rlen_q,
  output logic [LEN_W-1:0]  rows_q,
  output logic [LEN_W-1:0]  pitch_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              go_q
);
  logic [ADDR_W-1:0] base_d;
  logic [LEN_W-1:0]  rlen_d, rows_d, pitch_d;
  logic [CTL_W-1:0]  ctl_d;
  logic              go_d;

  always_comb begin
    base_d  = wdata[ADDR_W-1:0];
    rlen_d  = wdata[LEN_W-1:0];
    rows_d  = wdata[LEN_W-1:0];
    pitch_d = wdata[LEN_W-1:0];
    ctl_d   = wdata[CTL_W-1:0];
    // The address write is the arming event.
    go_d    = we_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      rlen_q  <= '0;
      rows_q  <= '0;
      pitch_q <= '0;
      ctl_q   <= '0;
      go_q    <= 1'b0;
    end else begin
      if (we_base)  base_q  <= base_d;
      if (we_rlen)  rlen_q  <= rlen_d;
      if (we_rows)  rows_q  <= rows_d;
      if (we_pitch) pitch_q <= pitch_d;
      if (we_ctl)   ctl_q   <= ctl_d;
      go_q <= go_d;
    end
  end
endmodule

// File: rtl/chan_dma_evt_bank.sv
module chan_dma_evt_bank
  import chan_dma_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     wdata,
  input  logic            we_stat,
  input  logic            we_ien,
  input  logic            we_loop,
  input  logic            we_stop,
  input  logic [N_CH-1:0] evt_any,
  output logic [N_CH-1:0] stat_q,
  output logic [N_CH-1:0] ien_q,
  output logic [31:0]     loop_q,
  output logic [N_CH-1:0] halt_q,
  output logic [N_CH-1:0] loop_on,
  output logic            irq
);
  logic [N_CH-1:0] stat_d, clr_mask, ien_d, halt_d;
  logic [31:0]     loop_d;

  always_comb begin
    clr_mask = we_stat ? wdata[N_CH-1:0] : '0;
    // Events are ORed in after the clear, so a colliding event survives.
    stat_d   = (stat_q & ~clr_mask) | evt_any;
    ien_d    = wdata[N_CH-1:0];
    loop_d   = wdata;
    halt_d   = we_stop ? wdata[N_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      loop_q <= '0;
      halt_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (we_ien)  ien_q  <= ien_d;
      if (we_loop) loop_q <= loop_d;
      halt_q <= halt_d;
    end
  end

  assign loop_on = loop_q[N_CH-1:0] & loop_q[LOOP_PAIR +: N_CH];
  assign irq     = |(stat_q & ien_q);
endmodule

// File: rtl/chan_dma_csr.sv
module chan_dma_csr
  import chan_dma_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [BA_W-1:0]          bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [N_CH-1:0]          evt_done,
  input  logic [N_CH-1:0]          evt_half,
  output logic [N_CH-1:0]          go_pulse,
  output logic [N_CH-1:0]          halt_pulse,
  output logic [N_CH*ADDR_W-1:0]   ch_base,
  output logic [N_CH*LEN_W-1:0]    ch_rowlen,
  output logic [N_CH*LEN_W-1:0]    ch_rows,
  output logic [N_CH*LEN_W-1:0]    ch_pitch,
  output logic [N_CH-1:0]          ch_burst4,
  output logic [N_CH-1:0]          ch_to_dev,
  output logic [N_CH-1:0]          ch_loop,
  output logic                     irq
);
  localparam int CH_W = $clog2(N_CH);
  localparam logic [WA_W-1:0] W_CH_END    = WA_W'(N_CH * 4);
  localparam logic [WA_W-1:0] W_PITCH_END = W_PITCH0 + WA_W'(N_CH);

  logic rst_sync_n;

  chan_dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // ---------------- address decode ----------------
  logic [WA_W-1:0] word;
  logic            wr, rd;
  logic            hit_ch, hit_pitch;
  logic [CH_W-1:0] ch_idx, pitch_idx;
  logic [WA_W-1:0] pitch_off;
  ch_sel_e         sel;

  always_comb begin
    word      = bus_addr[BA_W-1:2];
    wr        = bus_sel & bus_we;
    rd        = bus_sel & ~bus_we;
    hit_ch    = (word < W_CH_END);
    hit_pitch = (word >= W_PITCH0) && (word < W_PITCH_END);
    ch_idx    = word[CH_W+1:2];
    sel       = ch_sel_e'(word[1:0]);
    pitch_off = word - W_PITCH0;
    pitch_idx = pitch_off[CH_W-1:0];
  end

  // ---------------- per-channel register sets ----------------
  logic [N_CH-1:0][ADDR_W-1:0] base_a;
  logic [N_CH-1:0][LEN_W-1:0]  rlen_a, rows_a, pitch_a;
  logic [N_CH-1:0][CTL_W-1:0]  ctl_a;
  logic [N_CH-1:0]             we_base, we_rlen, we_rows, we_ctl, we_pitch;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic own_ch, own_pitch;
    assign own_ch      = wr && hit_ch && (ch_idx == CH_W'(g));
    assign own_pitch   = wr && hit_pitch && (pitch_idx == CH_W'(g));
    assign we_base[g]  = own_ch && (sel == SEL_BASE);
    assign we_rlen[g]  = own_ch && (sel == SEL_RLEN);
    assign we_rows[g]  = own_ch && (sel == SEL_ROWS);
    assign we_ctl[g]   = own_ch && (sel == SEL_CTL);
    assign we_pitch[g] = own_pitch;

    chan_dma_chregs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_sync_n), .wdata(bus_wdata),
      .we_base(we_base[g]), .we_rlen(we_rlen[g]), .we_rows(we_rows[g]),
      .we_ctl(we_ctl[g]), .we_pitch(we_pitch[g]),
      .base_q(base_a[g]), .rlen_q(rlen_a[g]), .rows_q(rows_a[g]),
      .pitch_q(pitch_a[g]), .ctl_q(ctl_a[g]), .go_q(go_pulse[g])
    );

    assign ch_base[g*ADDR_W +: ADDR_W] = base_a[g];
    assign ch_rowlen[g*LEN_W +: LEN_W] = rlen_a[g];
    assign ch_rows[g*LEN_W +: LEN_W]   = rows_a[g];
    assign ch_pitch[g*LEN_W +: LEN_W]  = pitch_a[g];
    assign ch_burst4[g]                = ctl_a[g][CTL_BURST];
    assign ch_to_dev[g]                = ctl_a[g][CTL_DIR];
  end

  // ---------------- shared status / enable / loop / stop ----------------
  logic [N_CH-1:0] evt_any, stat_q, ien_q;
  logic [31:0]     loop_q;

  assign evt_any = evt_done | evt_half;

  chan_dma_evt_bank #(.N_CH(N_CH)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wdata(bus_wdata),
    .we_stat(wr && word == W_STAT), .we_ien(wr && word == W_IEN),
    .we_loop(wr && word == W_LOOP), .we_stop(wr && word == W_STOP),
    .evt_any(evt_any), .stat_q(stat_q), .ien_q(ien_q), .loop_q(loop_q),
    .halt_q(halt_pulse), .loop_on(ch_loop), .irq(irq)
  );

  // ---------------- read path ----------------
  logic [31:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    if (hit_ch) begin
      unique case (sel)
        SEL_BASE: rdata_d = 32'(base_a[ch_idx]);
        SEL_RLEN: rdata_d = 32'(rlen_a[ch_idx]);
        SEL_ROWS: rdata_d = 32'(rows_a[ch_idx]);
        SEL_CTL:  rdata_d = 32'(ctl_a[ch_idx]);
        default:  rdata_d = '0;
      endcase
    end else if (hit_pitch) begin
      rdata_d = 32'(pitch_a[pitch_idx]);
    end else begin
      unique case (word)
        W_STAT:  rdata_d = 32'(stat_q);
        W_IEN:   rdata_d = 32'(ien_q);
        W_LOOP:  rdata_d = loop_q;
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bus_rdata <= '0;
    else if (rd)      bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/chan_dma_csr_chk.sv
module chan_dma_csr_chk #(
  parameter int N_CH = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_we,
  input logic [8:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [N_CH-1:0] go,
  input logic [N_CH-1:0] halt,
  input logic [N_CH-1:0] evt,
  input logic [N_CH-1:0] stat
);
  localparam int CH_W = $clog2(N_CH);
  logic [N_CH-1:0] exp_go, exp_halt;

  always_comb begin
    exp_go   = '0;
    exp_halt = '0;
    if (bus_sel && bus_we && (bus_addr[3:2] == 2'd0) &&
        (int'(bus_addr) < N_CH * 16))
      exp_go = N_CH'(1) << bus_addr[CH_W+3:4];
    if (bus_sel && bus_we && (bus_addr == 9'h140))
      exp_halt = bus_wdata[N_CH-1:0];
  end

  a_r3_go_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go));

  a_r3_go_follows_base_write: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (go == $past(exp_go)));

  a_r5_halt_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (halt == $past(exp_halt)));

  a_r6_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));
endmodule

bind chan_dma_csr chan_dma_csr_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .go(go_pulse),
  .halt(halt_pulse), .evt(evt_any), .stat(stat_q)
);

// File: tb/chan_dma_csr_tb.sv
`timescale 1ns/1ps
module chan_dma_csr_tb;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] evt_done = '0, evt_half = '0;
  logic [N-1:0] go_pulse, halt_pulse, ch_burst4, ch_to_dev, ch_loop;
  logic [N*32-1:0] ch_base;
  logic [N*16-1:0] ch_rowlen, ch_rows, ch_pitch;
  logic irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  chan_dma_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(evt_done), .evt_half(evt_half), .go_pulse(go_pulse),
    .halt_pulse(halt_pulse), .ch_base(ch_base), .ch_rowlen(ch_rowlen),
    .ch_rows(ch_rows), .ch_pitch(ch_pitch), .ch_burst4(ch_burst4),
    .ch_to_dev(ch_to_dev), .ch_loop(ch_loop), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [N-1:0] dn, input logic [N-1:0] hf);
    @(negedge clk); evt_done = dn; evt_half = hf;
    @(negedge clk); evt_done = '0; evt_half = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(9'h000, v); chk("R1 base0", v, 32'h0);
    rd(9'h144, v); chk("R1 status", v, 32'h0);
    rd(9'h150, v); chk("R1 loop", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 go", {16'b0, go_pulse}, 32'h0);
    chk("R1 halt", {16'b0, halt_pulse}, 32'h0);
  endtask

  task automatic t_chregs;
    logic [31:0] v;
    wr(9'h034, 32'hFFFF_ABCD); rd(9'h034, v); chk("R2 rowlen ch3", v, 32'h0000_ABCD);
    wr(9'h038, 32'h0001_0007); rd(9'h038, v); chk("R2 rows ch3", v, 32'h0000_0007);
    wr(9'h03C, 32'hFFFF_FFFF); rd(9'h03C, v); chk("R2 ctl ch3", v, 32'h0000_003F);
    wr(9'h030, 32'hDEAD_BEEF); rd(9'h030, v); chk("R2 base ch3", v, 32'hDEAD_BEEF);
    rd(9'h044, v); chk("R2 rowlen ch4 untouched", v, 32'h0);
  endtask

  task automatic t_launch;
    wr(9'h054, 32'h0000_0040);
    chk("R3 no go on rowlen", {16'b0, go_pulse}, 32'h0);
    wr(9'h058, 32'h0000_0003);
    wr(9'h05C, 32'h0000_0035);
    chk("R3 no go on ctl", {16'b0, go_pulse}, 32'h0);
    wr(9'h050, 32'h8000_1000);
    chk("R3 go ch5", {16'b0, go_pulse}, 32'h0000_0020);
    chk("R3 base out", ch_base[5*32 +: 32], 32'h8000_1000);
    chk("R3 rowlen out", {16'b0, ch_rowlen[5*16 +: 16]}, 32'h40);
    chk("R3 rows out", {16'b0, ch_rows[5*16 +: 16]}, 32'h3);
    chk("R11 burst ch5", {31'b0, ch_burst4[5]}, 32'h1);
    chk("R11 dir ch5", {31'b0, ch_to_dev[5]}, 32'h1);
    @(negedge clk);
    chk("R3 go single cycle", {16'b0, go_pulse}, 32'h0);
    wr(9'h06C, 32'h0000_0010);
    chk("R11 burst ch6", {31'b0, ch_burst4[6]}, 32'h1);
    chk("R11 dir ch6 dev-to-mem", {31'b0, ch_to_dev[6]}, 32'h0);
  endtask

  task automatic t_pitch;
    logic [31:0] v;
    wr(9'h13C, 32'h0000_1234); rd(9'h13C, v); chk("R4 pitch ch15", v, 32'h1234);
    chk("R4 pitch out ch15", {16'b0, ch_pitch[15*16 +: 16]}, 32'h1234);
    wr(9'h100, 32'h0000_0009); rd(9'h100, v); chk("R4 pitch ch0", v, 32'h9);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    wr(9'h140, 32'h0000_8001);
    chk("R5 halt pulse", {16'b0, halt_pulse}, 32'h8001);
    @(negedge clk);
    chk("R5 halt single", {16'b0, halt_pulse}, 32'h0);
    rd(9'h140, v); chk("R5 reads zero", v, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    pulse_evt(16'h0004, 16'h0);
    rd(9'h144, v); chk("R6 done sets", v, 32'h4);
    chk("R9 masked", {31'b0, irq}, 32'h0);
    pulse_evt(16'h0, 16'h0200);
    rd(9'h144, v); chk("R6 half sets", v, 32'h204);
    wr(9'h148, 32'h0000_0200);
    chk("R9 enabled irq", {31'b0, irq}, 32'h1);
    rd(9'h148, v); chk("R9 enable readback", v, 32'h200);
    wr(9'h148, 32'h0000_0001);
    chk("R9 other enable", {31'b0, irq}, 32'h0);
    wr(9'h144, 32'h0000_0004);
    rd(9'h144, v); chk("R7 clear one", v, 32'h200);
    wr(9'h144, 32'h0000_0000);
    rd(9'h144, v); chk("R7 zero ignored", v, 32'h200);
  endtask

  task automatic t_race;
    logic [31:0] v;
    @(negedge clk);
    evt_done = 16'h0080; bus_sel = 1; bus_we = 1; bus_addr = 9'h144;
    bus_wdata = 32'h0000_0280;
    @(negedge clk);
    evt_done = '0; bus_sel = 0; bus_we = 0;
    rd(9'h144, v); chk("R8 event beats clear", v, 32'h80);
  endtask

  task automatic t_loop;
    logic [31:0] v;
    wr(9'h150, 32'h0001_0000);
    chk("R10 high bit only", {16'b0, ch_loop}, 32'h0);
    wr(9'h150, 32'h0000_0001);
    chk("R10 low bit only", {16'b0, ch_loop}, 32'h0);
    wr(9'h150, 32'h0003_0002);
    chk("R10 pair ch1", {16'b0, ch_loop}, 32'h2);
    rd(9'h150, v); chk("R10 readback", v, 32'h0003_0002);
    wr(9'h150, 32'h0);
    chk("R10 off", {16'b0, ch_loop}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_chregs();
    t_launch();
    t_pitch();
    t_stop();
    t_events();
    t_race();
    t_loop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule